// File: doc/BRIEF.md
# Subblocked Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each entry holds a single tag for an aligned group of adjacent virtual pages, so one compare covers several pages. A lookup supplies a virtual page number. One cycle later the block returns one of three results: a hit with the physical page number, a miss, or a "not resident" status. The third result means the group is cached but the addressed subpage is not mapped. A refill port, usually driven by a page table walker, writes a whole group at once. A single flush input empties the cache.

The parameter `PARTIAL` selects the storage mode. In complete mode (`PARTIAL=0`) every subpage has its own frame number and valid bit, so its frames can lie anywhere in physical memory. In partial mode (`PARTIAL=1`) the group's frames form one aligned contiguous block. The entry keeps one base frame and a residency bitmap, and the frame for subpage i is the base plus i.

Lookups use a valid/ready request and a valid/ready response. The rules for back-pressure are:
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no response is pending, or the pending response is being taken in the same cycle.
- A response that is not taken stays unchanged.
- The refill port never stalls.

Top module: `subblock_tlb`

## Requirements
- R1: After reset `rsp_valid` is low, `req_ready` is high, and every entry is invalid, so the first lookup reports a miss.
- R2: A lookup accepted at a clock edge gives `rsp_valid` high after that edge. The result reflects the entries as they stood before that edge, so a refill at the same edge is not visible to it.
- R3: While `rsp_valid` is high and `rsp_ready` is low, the response holds its status and frame number, and `req_ready` is low.
- R4: `rsp_status` is 2'b01 for a hit, 2'b00 for a miss (no tag match) and 2'b10 for a tag match whose subpage is not resident. `rsp_ppn` is zero unless the status is a hit. The code 2'b11 never appears.
- R5: The subpage index is the low log2(`FACTOR`) bits of the VPN, and the tag is the remaining upper bits. `FACTOR` is a power of two.
- R6: Complete mode: a hit returns frame slot `idx` of the refill data, held at bits `idx*PPN_W` upward. That slot is resident when bit `idx` of the refill mask is set.
- R7: Partial mode: a hit returns slot 0 of the refill data plus `idx`, and it is gated by bit `idx` of the refill mask.
- R8: A refill whose tag equals a valid entry's tag rewrites that entry in place, so at most one entry matches any tag.
- R9: A refill with a new tag goes to a round-robin victim that starts at entry 0 and advances only on such allocations, whether or not the victim is valid.
- R10: `flush` clears every entry in one cycle and takes precedence over a refill at the same edge.
- R11: `fill_ready` is always high, and a refill takes effect at the clock edge where `fill_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_status | output | 2 | 01 hit, 00 miss, 10 not resident |
| rsp_ppn | output | PPN_W | Physical page number on a hit, else zero |
| fill_valid | input | 1 | Refill write strobe |
| fill_ready | output | 1 | Always high |
| fill_tag | input | VPN_W-log2(FACTOR) | Group tag to write |
| fill_ppn | input | FACTOR*PPN_W | Frame slots, slot i at bits i*PPN_W |
| fill_mask | input | FACTOR | Per-subpage valid / residency bits |
| flush | input | 1 | Invalidate every entry |

## Verification
Every lookup result is due in the first cycle after the edge that accepts the request. The bench drives inputs on the falling edge and samples the response on the next falling edge, one rising edge later. A refill or flush takes effect at its own rising edge, so the bench lets that edge pass before it issues the lookup that checks it. For back-pressure, the bench holds `rsp_ready` low across several edges and compares the held response after each one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ST_MISS   = 2'b00,
    ST_HIT    = 2'b01,
    ST_ABSENT = 2'b10
  } tlb_status_e;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (advance) ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 18,
  parameter int PPN_W   = 16,
  parameter int FACTOR  = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [FACTOR*PPN_W-1:0] wr_ppn,
  input  logic [FACTOR-1:0]       wr_mask,
  input  logic [IW-1:0]           victim,
  output logic                    alloc,
  input  logic [TAG_W-1:0]        look_tag,
  output logic [ENTRIES-1:0]      match_vec,
  output logic [FACTOR*PPN_W-1:0] rd_ppn,
  output logic [FACTOR-1:0]       rd_mask
);
  logic [ENTRIES-1:0]      vld;
  logic [TAG_W-1:0]        tag  [ENTRIES];
  logic [FACTOR*PPN_W-1:0] ppn  [ENTRIES];
  logic [FACTOR-1:0]       mask [ENTRIES];
  logic [ENTRIES-1:0]      wr_match;
  logic [ENTRIES-1:0]      wr_sel;

  assign alloc = wr_en && !flush && (wr_match == '0);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign match_vec[e] = vld[e] && (tag[e] == look_tag);
    assign wr_match[e]  = vld[e] && (tag[e] == wr_tag);
    assign wr_sel[e]    = wr_en && ((wr_match != '0) ? wr_match[e] : (victim == IW'(e)));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        vld[e] <= 1'b0;
      end else if (wr_sel[e]) begin
        vld[e]  <= 1'b1;
        tag[e]  <= wr_tag;
        ppn[e]  <= wr_ppn;
        mask[e] <= wr_mask;
      end
    end
  end

  always_comb begin
    rd_ppn  = '0;
    rd_mask = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) begin
        rd_ppn  = rd_ppn | ppn[e];
        rd_mask = rd_mask | mask[e];
      end
    end
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int  FACTOR  = 4,
  parameter int  PPN_W   = 16,
  parameter bit  PARTIAL = 1'b0,
  localparam int SW = (FACTOR > 1) ? $clog2(FACTOR) : 1
) (
  input  logic                    tag_hit,
  input  logic [SW-1:0]           idx,
  input  logic [FACTOR*PPN_W-1:0] rd_ppn,
  input  logic [FACTOR-1:0]       rd_mask,
  output tlb_status_e             status,
  output logic [PPN_W-1:0]        ppn
);
  logic             present;
  logic [PPN_W-1:0] frame;

  assign present = rd_mask[idx];

  if (PARTIAL) begin : g_partial
    assign frame = rd_ppn[PPN_W-1:0] + PPN_W'(idx);
  end else begin : g_complete
    assign frame = rd_ppn[idx*PPN_W +: PPN_W];
  end

  always_comb begin
    status = ST_MISS;
    ppn    = '0;
    if (tag_hit) begin
      if (present) begin
        status = ST_HIT;
        ppn    = frame;
      end else begin
        status = ST_ABSENT;
      end
    end
  end
endmodule

// File: rtl/subblock_tlb.sv
module subblock_tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int ENTRIES = 4,
  parameter int FACTOR  = 4,
  parameter bit PARTIAL = 1'b0,
  localparam int SW    = (FACTOR > 1) ? $clog2(FACTOR) : 1,
  localparam int TAG_W = VPN_W - SW,
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VPN_W-1:0]        req_vpn,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [1:0]              rsp_status,
  output logic [PPN_W-1:0]        rsp_ppn,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [FACTOR*PPN_W-1:0] fill_ppn,
  input  logic [FACTOR-1:0]       fill_mask,
  input  logic                    flush
);
  logic [IW-1:0]           victim;
  logic                    alloc;
  logic [ENTRIES-1:0]      match_vec;
  logic [FACTOR*PPN_W-1:0] rd_ppn;
  logic [FACTOR-1:0]       rd_mask;
  tlb_status_e             look_status;
  logic [PPN_W-1:0]        look_ppn;
  logic                    accept;

  assign fill_ready = 1'b1;
  assign req_ready  = !rsp_valid || rsp_ready;
  assign accept     = req_valid && req_ready;

  tlb_rr_ptr #(.N(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .advance(alloc), .ptr(victim)
  );

  tlb_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W), .FACTOR(FACTOR)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fill_valid), .wr_tag(fill_tag), .wr_ppn(fill_ppn), .wr_mask(fill_mask),
    .victim(victim), .alloc(alloc),
    .look_tag(req_vpn[VPN_W-1:SW]), .match_vec(match_vec),
    .rd_ppn(rd_ppn), .rd_mask(rd_mask)
  );

  tlb_resolve #(.FACTOR(FACTOR), .PPN_W(PPN_W), .PARTIAL(PARTIAL)) u_res (
    .tag_hit(match_vec != '0), .idx(req_vpn[SW-1:0]),
    .rd_ppn(rd_ppn), .rd_mask(rd_mask),
    .status(look_status), .ppn(look_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_ppn    <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_status <= look_status;
      rsp_ppn    <= look_ppn;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int PPN_W   = 16,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [1:0]         rsp_status,
  input logic [PPN_W-1:0]   rsp_ppn,
  input logic [ENTRIES-1:0] match_vec
);
  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_ppn)));
  // R3
  stall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R4
  ppn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'b01) |-> (rsp_ppn == '0));
  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'b11));
  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

bind subblock_tlb tlb_chk #(.PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_ppn(rsp_ppn), .match_vec(match_vec)
);

// File: tb/tb_subblock_tlb.sv
module tb_subblock_tlb;
  localparam int VPN_W = 20, PPN_W = 16, ENTRIES = 4, FACTOR = 4, TAG_W = 18;
  localparam logic [1:0] HIT = 2'b01, MISS = 2'b00, ABS = 2'b10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1, fill_valid = 0, flush = 0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [FACTOR*PPN_W-1:0] fill_ppn = '0;
  logic [FACTOR-1:0] fill_mask = '0;
  logic c_rrdy, c_rv, c_fr, p_rrdy, p_rv, p_fr;
  logic [1:0] c_st, p_st;
  logic [PPN_W-1:0] c_pp, p_pp;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  subblock_tlb #(.PARTIAL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(c_rrdy), .req_vpn(req_vpn),
    .rsp_valid(c_rv), .rsp_ready(rsp_ready), .rsp_status(c_st), .rsp_ppn(c_pp),
    .fill_valid(fill_valid), .fill_ready(c_fr), .fill_tag(fill_tag), .fill_ppn(fill_ppn),
    .fill_mask(fill_mask), .flush(flush));

  subblock_tlb #(.PARTIAL(1'b1)) dut_p (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(p_rrdy), .req_vpn(req_vpn),
    .rsp_valid(p_rv), .rsp_ready(rsp_ready), .rsp_status(p_st), .rsp_ppn(p_pp),
    .fill_valid(fill_valid), .fill_ready(p_fr), .fill_tag(fill_tag), .fill_ppn(fill_ppn),
    .fill_mask(fill_mask), .flush(flush));

  // vector: vpn, complete status, complete ppn, partial status, partial ppn
  localparam int VW = VPN_W + 2 + PPN_W + 2 + PPN_W;
  localparam logic [VW-1:0] VEC [5] = '{
    {20'h00040, HIT,  16'h0100, HIT,  16'h0100},
    {20'h00041, HIT,  16'h02A0, HIT,  16'h0101},
    {20'h00042, ABS,  16'h0000, ABS,  16'h0000},
    {20'h00043, HIT,  16'h0777, HIT,  16'h0103},
    {20'h00080, MISS, 16'h0000, MISS, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic fill(input logic [TAG_W-1:0] t, input logic [FACTOR*PPN_W-1:0] p,
                      input logic [FACTOR-1:0] m, input logic fl);
    @(negedge clk);
    fill_valid = 1; fill_tag = t; fill_ppn = p; fill_mask = m; flush = fl;
    @(negedge clk);
    fill_valid = 0; flush = 0;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v,
                      input logic [1:0] cs, input logic [PPN_W-1:0] cp,
                      input logic [1:0] ps, input logic [PPN_W-1:0] pp);
    @(negedge clk);
    req_valid = 1; req_vpn = v;
    @(negedge clk);
    req_valid = 0;
    chk({req, " complete valid"}, 32'(c_rv), 1);
    chk({req, " complete status"}, 32'(c_st), 32'(cs));
    chk({req, " complete ppn"}, 32'(c_pp), 32'(cp));
    chk({req, " partial status"}, 32'(p_st), 32'(ps));
    chk({req, " partial ppn"}, 32'(p_pp), 32'(pp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(c_rv), 0);
    chk("R1 req_ready", 32'(c_rrdy), 1);
    chk("R11 fill_ready", 32'(c_fr & p_fr), 1);
    look("R1 empty", 20'h00040, MISS, 0, MISS, 0);

    // R2: lookup and refill at the same edge sees old contents
    @(negedge clk);
    req_valid = 1; req_vpn = 20'h00040;
    fill_valid = 1; fill_tag = 18'h00010;
    fill_ppn = {16'h0777, 16'h0033, 16'h02A0, 16'h0100}; fill_mask = 4'b1011;
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    chk("R2 same-edge refill hidden", 32'(c_st), 32'(MISS));

    // R5 R6 R7 table walk
    for (int i = 0; i < 5; i++) begin
      look("R6 R7 R5 vector", VEC[i][VW-1 -: VPN_W], VEC[i][35:34], VEC[i][33:18],
           VEC[i][17:16], VEC[i][15:0]);
    end

    // R8 overwrite in place
    fill(18'h00010, {16'h0903, 16'h0902, 16'h0901, 16'h0900}, 4'b1111, 0);
    look("R8 overwrite", 20'h00042, HIT, 16'h0902, HIT, 16'h0902);

    // R9 fill three new tags, then a fourth evicts entry 0 (tag 0x10)
    for (int t = 1; t <= 3; t++)
      fill(TAG_W'(t), {PPN_W'(t*256+3), PPN_W'(t*256+2), PPN_W'(t*256+1), PPN_W'(t*256)}, 4'b1111, 0);
    look("R8 still present", 20'h00040, HIT, 16'h0900, HIT, 16'h0900);
    fill(18'h4, {16'h0403, 16'h0402, 16'h0401, 16'h0400}, 4'b1111, 0);
    look("R9 victim evicted", 20'h00040, MISS, 0, MISS, 0);
    look("R9 new entry", 20'h00013, HIT, 16'h0403, HIT, 16'h0403);
    look("R9 survivor", 20'h00005, HIT, 16'h0101, HIT, 16'h0101);

    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vpn = 20'h00006;
    @(negedge clk);
    req_vpn = 20'h00040;
    chk("R3 held valid", 32'(c_rv), 1);
    chk("R3 req_ready low", 32'(c_rrdy), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R3 held status", 32'(c_st), 32'(HIT));
    chk("R3 held ppn", 32'(c_pp), 32'h0102);
    rsp_ready = 1;
    @(negedge clk);
    chk("R3 released", 32'(c_rv), 0);

    // R10 flush wins over a simultaneous refill
    fill(18'h5, {16'h0503, 16'h0502, 16'h0501, 16'h0500}, 4'b1111, 1);
    look("R10 flushed refill", 20'h00014, MISS, 0, MISS, 0);
    look("R10 flushed entry", 20'h00005, MISS, 0, MISS, 0);
    finish_run();
  end
endmodule